// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block produces the 20-bit physical addresses a 16-bit processor core needs for two kinds of access: instruction fetch and data operands. It keeps four 16-bit segment registers (extra, code, stack, data) and a 16-bit instruction pointer. The fetch address comes from the code segment and the instruction pointer. The data address is computed combinationally in the same cycle from operand values that the decoder supplies.

A data access presents a base value, an index value, a displacement and a 2-bit mode. The unit forms a 16-bit effective address from these inputs, wrapping modulo 2^16. It then picks a segment: the data segment by default, or the stack segment when the base is the base pointer. An explicit override replaces that choice when one is given. The physical address is the chosen segment shifted left by four bits plus the effective address, truncated to 20 bits. Segments are at most 64 KB and may overlap.

The instruction pointer moves in one of three ways. It advances by the length of the instruction just fetched. A near relative branch adds a signed displacement to it. A far branch loads both the code segment and the instruction pointer.

Top module: `seg_addr_unit`

## Requirements
- R1: After a synchronous active-low reset, the code segment is RESET_CS (default 16'hFFFF), the instruction pointer is 0 and the other three segments are 0, so fetch_addr reads 20'hFFFF0.
- R2: fetch_addr always equals (CS << 4) + IP, modulo 2^20, taken from the registered code segment and instruction pointer.
- R3: data_ea is computed modulo 2^16 for each ea_mode: 0 gives base; 1 gives base + displacement; 2 gives base + index; 3 gives base + index + displacement.
- R4: With disp_wide = 0, the displacement is disp_val[7:0] sign-extended to 16 bits. With disp_wide = 1, the displacement is all of disp_val.
- R5: With no override, data_seg is 3 (data segment). When base_is_bp = 1, it is 2 (stack segment). The segment codes are ES = 0, CS = 1, SS = 2, DS = 3.
- R6: When ovr_valid = 1, data_seg equals ovr_sel and the data address uses that segment. The override has no effect on fetch_addr.
- R7: data_addr equals (selected segment << 4) + data_ea, modulo 2^20, in the same cycle as its inputs.
- R8: When seg_wr_en = 1, the segment coded by seg_wr_sel takes seg_wr_data at the clock edge. The new value is used from the next cycle on.
- R9: A near branch sets IP to IP + br_disp modulo 2^16 and leaves the code segment unchanged.
- R10: A far branch loads the code segment from br_far_cs and IP from br_far_ip. It takes priority over a near branch, over an IP advance and over a segment write aimed at the code segment in the same cycle.
- R11: Without a branch, ip_adv_en adds the 3-bit ip_adv_len to IP modulo 2^16. A near branch takes priority over an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment to write (ES=0, CS=1, SS=2, DS=3) |
| seg_wr_data | input | 16 | Value to write |
| ip_adv_en | input | 1 | Advance IP after a fetch |
| ip_adv_len | input | 3 | Number of bytes to advance |
| br_near_en | input | 1 | Near relative branch |
| br_disp | input | 16 | Signed near-branch displacement |
| br_far_en | input | 1 | Far branch |
| br_far_cs | input | 16 | New code segment for a far branch |
| br_far_ip | input | 16 | New IP for a far branch |
| base_val | input | 16 | Base register value |
| index_val | input | 16 | Index register value |
| disp_val | input | 16 | Operand displacement |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = 8-bit sign-extended |
| ea_mode | input | 2 | Effective-address mode (see R3) |
| base_is_bp | input | 1 | Base value comes from the base pointer |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| data_ea | output | 16 | Effective address |
| data_seg | output | 2 | Segment code used for the data access |
| data_addr | output | 20 | Physical data address |
| fetch_addr | output | 20 | Physical fetch address |

## Verification
The register-update assertions assume the control strobes are known whenever reset is released. They also assume the IP-change properties are read against the documented priority: far branch, then near branch, then advance. The segment-choice assertions assume ovr_sel is meaningful only while ovr_valid is high. The random stimulus drives every input to a defined value on every cycle and asserts the branch strobes with low probability, so that advances and segment writes also get a chance to take effect. Directed cases add simultaneous far branches, code-segment writes and near branches to exercise the priority order.

// File: rtl/agu_pkg.sv
// Package: shared segment codes and effective-address mode encoding.
// Assumes a two-bit segment code space with exactly four segments.
package agu_pkg;
    localparam int NSEG = 4;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_code_e;

    typedef enum logic [1:0] {
        EA_BASE          = 2'd0,
        EA_BASE_DISP     = 2'd1,
        EA_BASE_IDX      = 2'd2,
        EA_BASE_IDX_DISP = 2'd3
    } ea_mode_e;
endpackage

// File: rtl/agu_seg_regs.sv
// Segment register file plus instruction pointer.
// Holds one register per segment code; the code segment register and the
// IP also take branch updates. Priority for the IP: far > near > advance.
// A far branch overrides a same-cycle software write to the code segment.
module agu_seg_regs
    import agu_pkg::*;
#(
    parameter int          OFS_W    = 16,
    parameter int          ADV_W    = 3,
    parameter logic [15:0] RESET_CS = 16'hFFFF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       seg_wr_en,
    input  logic [1:0]                 seg_wr_sel,
    input  logic [OFS_W-1:0]           seg_wr_data,
    input  logic                       ip_adv_en,
    input  logic [ADV_W-1:0]           ip_adv_len,
    input  logic                       br_near_en,
    input  logic [OFS_W-1:0]           br_disp,
    input  logic                       br_far_en,
    input  logic [OFS_W-1:0]           br_far_cs,
    input  logic [OFS_W-1:0]           br_far_ip,
    output logic [NSEG-1:0][OFS_W-1:0] seg_q,
    output logic [OFS_W-1:0]           ip_q
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        if (g == int'(SEG_CS)) begin : g_code
            // Code segment: far branch wins over a write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    seg_q[g] <= OFS_W'(RESET_CS);
                else if (br_far_en)
                    seg_q[g] <= br_far_cs;
                else if (seg_wr_en && seg_wr_sel == 2'(g))
                    seg_q[g] <= seg_wr_data;
            end
        end else begin : g_plain
            // Other segments: loaded only by an explicit write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    seg_q[g] <= '0;
                else if (seg_wr_en && seg_wr_sel == 2'(g))
                    seg_q[g] <= seg_wr_data;
            end
        end
    end

    // Instruction pointer: far load, near relative add, or sequential advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ip_q <= '0;
        else if (br_far_en)
            ip_q <= br_far_ip;
        else if (br_near_en)
            ip_q <= ip_q + br_disp;
        else if (ip_adv_en)
            ip_q <= ip_q + OFS_W'(ip_adv_len);
    end

    AST_FAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        br_far_en |=> (seg_q[SEG_CS] == $past(br_far_cs)) && (ip_q == $past(br_far_ip))); // R10
    AST_NEAR_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (br_near_en && !br_far_en && !(seg_wr_en && seg_wr_sel == SEG_CS))
        |=> (ip_q == OFS_W'($past(ip_q) + $past(br_disp))) && $stable(seg_q[SEG_CS])); // R9
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_adv_en && !br_near_en && !br_far_en)
        |=> ip_q == OFS_W'($past(ip_q) + OFS_W'($past(ip_adv_len)))); // R11
endmodule

// File: rtl/agu_ea_calc.sv
// Effective-address adder.
// Assumes the caller places whichever register serves as pointer on base
// for the single-register mode. The displacement is sign-extended from its
// low byte unless marked wide. All sums wrap modulo 2^OFS_W.
module agu_ea_calc
    import agu_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic [OFS_W-1:0] base_val,
    input  logic [OFS_W-1:0] index_val,
    input  logic [OFS_W-1:0] disp_val,
    input  logic             disp_wide,
    input  logic [1:0]       ea_mode,
    output logic [OFS_W-1:0] ea
);
    localparam int BYTE_W = 8;

    logic [OFS_W-1:0] disp_ext;
    logic [OFS_W-1:0] idx_term;
    logic [OFS_W-1:0] disp_term;

    // Widen the displacement to the offset width.
    always_comb begin
        if (disp_wide)
            disp_ext = disp_val;
        else
            disp_ext = {{(OFS_W-BYTE_W){disp_val[BYTE_W-1]}}, disp_val[BYTE_W-1:0]};
    end

    // Gate index and displacement terms by mode, then sum.
    always_comb begin
        idx_term  = '0;
        disp_term = '0;
        case (ea_mode_e'(ea_mode))
            EA_BASE:          ;
            EA_BASE_DISP:     disp_term = disp_ext;
            EA_BASE_IDX:      idx_term  = index_val;
            EA_BASE_IDX_DISP: begin
                idx_term  = index_val;
                disp_term = disp_ext;
            end
            default:          ;
        endcase
        ea = base_val + idx_term + disp_term;
    end
endmodule

// File: rtl/agu_seg_pick.sv
// Data segment selection.
// Default is the data segment; the stack segment when the base is the base
// pointer; an explicit override replaces either choice.
module agu_seg_pick
    import agu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_is_bp,
    input  logic       ovr_valid,
    input  logic [1:0] ovr_sel,
    output logic [1:0] seg_sel
);
    // Resolve the segment code for this access.
    always_comb begin
        if (ovr_valid)
            seg_sel = ovr_sel;
        else if (base_is_bp)
            seg_sel = SEG_SS;
        else
            seg_sel = SEG_DS;
    end

    AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid |-> seg_sel == ovr_sel); // R6
    AST_BP_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_valid && base_is_bp) |-> seg_sel == SEG_SS); // R5
    AST_DEFAULT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_valid && !base_is_bp) |-> seg_sel == SEG_DS); // R5
endmodule

// File: rtl/agu_phys_add.sv
// Physical address former: segment shifted left by SHIFT plus offset,
// truncated to the physical width OFS_W + SHIFT.
module agu_phys_add #(
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = OFS_W + SHIFT
) (
    input  logic [OFS_W-1:0] seg,
    input  logic [OFS_W-1:0] ofs,
    output logic [PA_W-1:0]  pa
);
    // Shift-and-add with natural truncation to PA_W bits.
    always_comb begin
        pa = {seg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, ofs};
    end
endmodule

// File: rtl/seg_addr_unit.sv
// Top of the segmented address generation unit.
// Fetch address uses the registered code segment and IP; data address is
// combinational from the current segment registers and operand inputs.
module seg_addr_unit
    import agu_pkg::*;
#(
    parameter int          OFS_W    = 16,
    parameter int          SHIFT    = 4,
    parameter int          ADV_W    = 3,
    parameter logic [15:0] RESET_CS = 16'hFFFF,
    localparam int         PA_W     = OFS_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [1:0]       seg_wr_sel,
    input  logic [OFS_W-1:0] seg_wr_data,
    input  logic             ip_adv_en,
    input  logic [ADV_W-1:0] ip_adv_len,
    input  logic             br_near_en,
    input  logic [OFS_W-1:0] br_disp,
    input  logic             br_far_en,
    input  logic [OFS_W-1:0] br_far_cs,
    input  logic [OFS_W-1:0] br_far_ip,
    input  logic [OFS_W-1:0] base_val,
    input  logic [OFS_W-1:0] index_val,
    input  logic [OFS_W-1:0] disp_val,
    input  logic             disp_wide,
    input  logic [1:0]       ea_mode,
    input  logic             base_is_bp,
    input  logic             ovr_valid,
    input  logic [1:0]       ovr_sel,
    output logic [OFS_W-1:0] data_ea,
    output logic [1:0]       data_seg,
    output logic [PA_W-1:0]  data_addr,
    output logic [PA_W-1:0]  fetch_addr
);
    logic [NSEG-1:0][OFS_W-1:0] seg_q;
    logic [OFS_W-1:0]           ip_q;

    agu_seg_regs #(.OFS_W(OFS_W), .ADV_W(ADV_W), .RESET_CS(RESET_CS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .ip_adv_en(ip_adv_en), .ip_adv_len(ip_adv_len),
        .br_near_en(br_near_en), .br_disp(br_disp),
        .br_far_en(br_far_en), .br_far_cs(br_far_cs), .br_far_ip(br_far_ip),
        .seg_q(seg_q), .ip_q(ip_q)
    );

    agu_ea_calc #(.OFS_W(OFS_W)) u_ea (
        .base_val(base_val), .index_val(index_val), .disp_val(disp_val),
        .disp_wide(disp_wide), .ea_mode(ea_mode), .ea(data_ea)
    );

    agu_seg_pick u_pick (
        .clk(clk), .rst_n(rst_n), .base_is_bp(base_is_bp),
        .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .seg_sel(data_seg)
    );

    agu_phys_add #(.OFS_W(OFS_W), .SHIFT(SHIFT)) u_pa_data (
        .seg(seg_q[data_seg]), .ofs(data_ea), .pa(data_addr)
    );

    agu_phys_add #(.OFS_W(OFS_W), .SHIFT(SHIFT)) u_pa_fetch (
        .seg(seg_q[SEG_CS]), .ofs(ip_q), .pa(fetch_addr)
    );

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_far_en && !br_near_en && !ip_adv_en && !(seg_wr_en && seg_wr_sel == SEG_CS))
        |=> $stable(fetch_addr)); // R2
    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_wr_en && seg_wr_sel == SEG_DS) |=> seg_q[SEG_DS] == $past(seg_wr_data)); // R8
endmodule

// File: tb/tb_seg_addr_unit.sv
module tb_seg_addr_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        ip_adv_en;
    logic [2:0]  ip_adv_len;
    logic        br_near_en;
    logic [15:0] br_disp;
    logic        br_far_en;
    logic [15:0] br_far_cs;
    logic [15:0] br_far_ip;
    logic [15:0] base_val, index_val, disp_val;
    logic        disp_wide;
    logic [1:0]  ea_mode;
    logic        base_is_bp, ovr_valid;
    logic [1:0]  ovr_sel;
    logic [15:0] data_ea;
    logic [1:0]  data_seg;
    logic [19:0] data_addr, fetch_addr;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_seg [4];
    logic [15:0] m_ip;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_addr_unit dut (.*);

    function automatic logic [15:0] f_ea(logic [1:0] md, logic [15:0] b, logic [15:0] x,
                                         logic [15:0] d, logic w);
        logic [15:0] dx;
        dx = w ? d : {{8{d[7]}}, d[7:0]};
        case (md)
            2'd0: return b;
            2'd1: return b + dx;
            2'd2: return b + x;
            default: return b + x + dx;
        endcase
    endfunction

    function automatic logic [19:0] f_pa(logic [15:0] s, logic [15:0] o);
        return ({s, 4'h0} + {4'h0, o});
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
        ip_adv_en = 0; ip_adv_len = 0; br_near_en = 0; br_disp = 0;
        br_far_en = 0; br_far_cs = 0; br_far_ip = 0;
        base_val = 0; index_val = 0; disp_val = 0; disp_wide = 0;
        ea_mode = 0; base_is_bp = 0; ovr_valid = 0; ovr_sel = 0;
    endtask

    // Inputs are already driven at a falling edge; check, clock, update model.
    task automatic step();
        logic [1:0]  es;
        logic [15:0] ee;
        #1;
        ee = f_ea(ea_mode, base_val, index_val, disp_val, disp_wide);
        es = ovr_valid ? ovr_sel : (base_is_bp ? 2'd2 : 2'd3);
        chk("R3/R4 data_ea", 32'(data_ea), 32'(ee));
        chk(ovr_valid ? "R6 data_seg" : "R5 data_seg", 32'(data_seg), 32'(es));
        chk("R7 data_addr", 32'(data_addr), 32'(f_pa(m_seg[es], ee)));
        chk("R2 fetch_addr", 32'(fetch_addr), 32'(f_pa(m_seg[1], m_ip)));
        @(posedge clk);
        if (seg_wr_en && !(br_far_en && seg_wr_sel == 2'd1)) m_seg[seg_wr_sel] = seg_wr_data;
        if (br_far_en) begin
            m_seg[1] = br_far_cs;
            m_ip = br_far_ip;
        end else if (br_near_en) m_ip = m_ip + br_disp;
        else if (ip_adv_en) m_ip = m_ip + 16'(ip_adv_len);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_seg[0] = 0; m_seg[1] = 16'hFFFF; m_seg[2] = 0; m_seg[3] = 0; m_ip = 0;
        #1;
        chk("R1 reset fetch", 32'(fetch_addr), 32'h000FFFF0);
        base_is_bp = 0;
        #1;
        chk("R1 reset ds", 32'(data_addr), 32'h0);

        // R8: load segments, then check use
        seg_wr_en = 1; seg_wr_sel = 2'd3; seg_wr_data = 16'h1234; step();
        seg_wr_sel = 2'd2; seg_wr_data = 16'hFFFF; step();
        seg_wr_sel = 2'd0; seg_wr_data = 16'h0B20; step();
        seg_wr_en = 0;
        // R3 wrap of effective address, R7 wrap of physical address via SS
        ea_mode = 2'd3; base_val = 16'hFFF0; index_val = 16'h0010; disp_val = 16'h0085;
        disp_wide = 0; base_is_bp = 1; step();
        chk("R7 wrap", 32'(f_pa(16'hFFFF, 16'hFF85)), 32'h0000FF75);
        // R4 wide displacement, R6 override to ES with fetch untouched
        disp_wide = 1; ovr_valid = 1; ovr_sel = 2'd0; step();
        ovr_valid = 0; base_is_bp = 0;
        // R11 advance, R9 near negative branch
        ip_adv_en = 1; ip_adv_len = 3'd7; step();
        ip_adv_en = 0; br_near_en = 1; br_disp = 16'hFFFC; step();
        br_near_en = 0; step();
        // R10 far wins over CS write, near and advance
        br_far_en = 1; br_far_cs = 16'h0100; br_far_ip = 16'h0020;
        seg_wr_en = 1; seg_wr_sel = 2'd1; seg_wr_data = 16'hAAAA;
        br_near_en = 1; br_disp = 16'h0300; ip_adv_en = 1; ip_adv_len = 3'd2; step();
        idle_inputs(); step();
        chk("R10 far result", 32'(fetch_addr), 32'h00001020);

        for (int i = 0; i < 3000; i++) begin
            seg_wr_en   = ($urandom % 4) == 0;
            seg_wr_sel  = 2'($urandom);
            seg_wr_data = 16'($urandom);
            ip_adv_en   = ($urandom % 2) == 0;
            ip_adv_len  = 3'($urandom);
            br_near_en  = ($urandom % 8) == 0;
            br_disp     = 16'($urandom);
            br_far_en   = ($urandom % 16) == 0;
            br_far_cs   = 16'($urandom);
            br_far_ip   = 16'($urandom);
            base_val    = 16'($urandom);
            index_val   = 16'($urandom);
            disp_val    = 16'($urandom);
            disp_wide   = 1'($urandom);
            ea_mode     = 2'($urandom);
            base_is_bp  = 1'($urandom);
            ovr_valid   = ($urandom % 4) == 0;
            ovr_sel     = 2'($urandom);
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule